// File: doc/BRIEF.md
# Interrupt Request Priority Controller

This block keeps the per-vector interrupt state of one processor core across 256 vectors. There are three bit sets: pending requests, vectors in service, and the trigger mode of each vector. It decides which vector the core should take next. Requests arrive on an accept port that carries a vector number and a level/edge flag. The controller answers each request one cycle later with an accepted pulse or a discarded pulse. A request is discarded when its vector is already pending.

The core raises an acknowledge strobe to take the highest pending vector into service. The acknowledge only acts when that vector's priority class is above the current processor priority. The processor priority is derived from a software-written task priority and from the highest vector in service. An end-of-interrupt strobe retires the highest vector in service. One cycle later it reports that vector together with its recorded trigger mode, so an upstream source can re-arm level-triggered lines. A one-cycle re-evaluation pulse is raised whenever the processor priority falls, because a pending vector that was blocked may now be deliverable.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, nothing is pending or in service, `irr_valid` and `isr_valid` are 0, `ppr` is 0, and `reeval`, `acc_ok`, `acc_dup` and `eoi_valid` are 0.
- R2: An accept (`acc_valid`=1, `sw_en`=1) of a vector of 16 or above that is not pending sets it pending and gives `acc_ok`=1 in the next cycle. An accept of a vector below 16 changes no state and raises neither result pulse.
- R3: An accept of a vector that is already pending leaves the pending set unchanged and gives `acc_dup`=1 in the next cycle. `acc_ok` and `acc_dup` are never both 1.
- R4: `irr_valid` is 1 exactly when some vector is pending. `irr_vec` is then the numerically highest pending vector, searched word by word from the top 32-bit word down, and is never below 16.
- R5: An accept records the vector's trigger mode, level when `acc_level`=1 and edge when `acc_level`=0. This also happens when the accept is discarded. `eoi_level` reports this recorded mode for the retired vector (1 = level).
- R6: `ppr` equals the 8-bit task priority when task priority bits [7:4] are greater than or equal to bits [7:4] of the highest in-service vector (0 when none is in service). Otherwise `ppr` equals the highest in-service vector with bits [3:0] cleared. A write on `tpr_we` takes effect on `ppr` from the next cycle.
- R7: On `ack`, if the highest pending vector's bits [7:4] are greater than `ppr[7:4]`, that vector leaves the pending set and enters the in-service set at the same clock edge. Otherwise `ack` has no effect.
- R8: On `eoi` with something in service, the highest in-service vector is removed. In the next cycle `eoi_valid`=1 and `eoi_vec` is that vector. With nothing in service, `eoi` has no effect and `eoi_valid` stays 0.
- R9: `reeval` is 1 for exactly the one cycle in which `ppr` is lower than it was in the previous cycle.
- R10: While `sw_en`=0, accepts change no state and raise no result pulse.
- R11: `isr_valid` is 1 exactly when some vector is in service. `isr_vec` is then the highest in-service vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_en | input | 1 | Software enable; accepts are ignored while low |
| acc_valid | input | 1 | Accept request strobe |
| acc_vector | input | 8 | Vector of the accept request |
| acc_level | input | 1 | 1 = level-triggered request, 0 = edge |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write value |
| ack | input | 1 | Core acknowledge: take highest pending vector into service |
| eoi | input | 1 | End of interrupt: retire highest in-service vector |
| irr_valid | output | 1 | Some vector is pending |
| irr_vec | output | 8 | Highest pending vector |
| isr_valid | output | 1 | Some vector is in service |
| isr_vec | output | 8 | Highest in-service vector |
| ppr | output | 8 | Processor priority |
| reeval | output | 1 | Processor priority dropped this cycle |
| acc_ok | output | 1 | Previous-cycle accept was newly recorded |
| acc_dup | output | 1 | Previous-cycle accept was discarded as already pending |
| eoi_valid | output | 1 | End-of-interrupt notification valid |
| eoi_vec | output | 8 | Retired vector |
| eoi_level | output | 1 | Trigger mode of the retired vector (1 = level) |

## Verification
The bench uses the default parameters: 256 vectors in 32-bit words, a floor of 16, and 4-bit priority classes. With these values the vectors used cover the floor word, interior words and the top word. The same setting lets one ack/eoi sequence cross several priority classes. Random traffic also reaches vectors below the floor and duplicate accepts arriving in the same cycle as acknowledges and retirements. Task-priority writes in that traffic move the class boundary both above and below the in-service class.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_VEC   = 256,
  parameter int WORD_W    = 32,
  parameter int MIN_VEC   = 16,
  parameter int CLASS_LSB = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sw_en,
  input  logic                       acc_valid,
  input  logic [$clog2(NUM_VEC)-1:0] acc_vector,
  input  logic                       acc_level,
  input  logic                       tpr_we,
  input  logic [$clog2(NUM_VEC)-1:0] tpr_wdata,
  input  logic                       ack,
  input  logic                       eoi,
  output logic                       irr_valid,
  output logic [$clog2(NUM_VEC)-1:0] irr_vec,
  output logic                       isr_valid,
  output logic [$clog2(NUM_VEC)-1:0] isr_vec,
  output logic [$clog2(NUM_VEC)-1:0] ppr,
  output logic                       reeval,
  output logic                       acc_ok,
  output logic                       acc_dup,
  output logic                       eoi_valid,
  output logic [$clog2(NUM_VEC)-1:0] eoi_vec,
  output logic                       eoi_level
);
  localparam int VW = $clog2(NUM_VEC);
  localparam int NW = NUM_VEC / WORD_W;
  localparam int CW = VW - CLASS_LSB;
  localparam logic [NUM_VEC-1:0] LIVE = {NUM_VEC{1'b1}} << MIN_VEC;
  localparam logic [NUM_VEC-1:0] ONE  = NUM_VEC'(1);

  logic [NUM_VEC-1:0] pend_q, serv_q, trig_q;
  logic [VW-1:0]      tpr_q, ppr_prev_q;

  // word-wise search from the top word down; MSB of first non-empty word wins
  function automatic logic [VW:0] top_bit(input logic [NUM_VEC-1:0] v);
    logic [VW:0] r;
    r = '0;
    for (int w = NW - 1; w >= 0; w--)
      if (!r[VW] && |v[w*WORD_W +: WORD_W])
        for (int b = WORD_W - 1; b >= 0; b--)
          if (!r[VW] && v[w*WORD_W + b])
            r = {1'b1, VW'(w*WORD_W + b)};
    return r;
  endfunction

  assign {irr_valid, irr_vec} = top_bit(pend_q & LIVE);
  assign {isr_valid, isr_vec} = top_bit(serv_q & LIVE);

  logic [CW-1:0] isr_cls;
  assign isr_cls = isr_valid ? isr_vec[VW-1:CLASS_LSB] : '0;
  assign ppr     = (tpr_q[VW-1:CLASS_LSB] >= isr_cls) ? tpr_q
                                                      : {isr_cls, {CLASS_LSB{1'b0}}};
  assign reeval  = ppr < ppr_prev_q;

  logic acc_go, acc_hit, ack_go, eoi_go;
  assign acc_go  = sw_en && acc_valid && (acc_vector >= VW'(MIN_VEC));
  assign acc_hit = pend_q[acc_vector];
  assign ack_go  = ack && irr_valid && (irr_vec[VW-1:CLASS_LSB] > ppr[VW-1:CLASS_LSB]);
  assign eoi_go  = eoi && isr_valid;

  logic [NUM_VEC-1:0] acc_oh, ack_oh, eoi_oh;
  assign acc_oh = (acc_go && !acc_hit) ? (ONE << acc_vector) : '0;
  assign ack_oh = ack_go ? (ONE << irr_vec) : '0;
  assign eoi_oh = eoi_go ? (ONE << isr_vec) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      serv_q     <= '0;
      trig_q     <= '0;
      tpr_q      <= '0;
      ppr_prev_q <= '0;
      acc_ok     <= 1'b0;
      acc_dup    <= 1'b0;
      eoi_valid  <= 1'b0;
      eoi_vec    <= '0;
      eoi_level  <= 1'b0;
    end else begin
      pend_q     <= (pend_q & ~ack_oh) | acc_oh;
      serv_q     <= (serv_q & ~eoi_oh) | ack_oh;
      if (acc_go) trig_q[acc_vector] <= acc_level;
      if (tpr_we) tpr_q <= tpr_wdata;
      ppr_prev_q <= ppr;
      acc_ok     <= acc_go && !acc_hit;
      acc_dup    <= acc_go && acc_hit;
      eoi_valid  <= eoi_go;
      eoi_vec    <= eoi_go ? isr_vec : '0;
      eoi_level  <= eoi_go && trig_q[isr_vec];
    end
  end

  a_r3_result_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_ok && acc_dup));
  a_r4_pending_floor: assert property (@(posedge clk) disable iff (!rst_n)
    irr_valid |-> irr_vec >= VW'(MIN_VEC));
  a_r11_service_floor: assert property (@(posedge clk) disable iff (!rst_n)
    isr_valid |-> isr_vec >= VW'(MIN_VEC));
  a_r6_ppr_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (ppr >= tpr_q) && (!isr_valid || ppr[VW-1:CLASS_LSB] >= isr_vec[VW-1:CLASS_LSB]));
  a_r8_eoi_reports: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr_valid) |=> (eoi_valid && eoi_vec == $past(isr_vec)));
  a_r8_eoi_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoi || !isr_valid) |=> !eoi_valid);
  a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> !(acc_ok || acc_dup));
  a_r9_drop_only: assert property (@(posedge clk) disable iff (!rst_n)
    reeval |-> ppr < $past(ppr));
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic sw_en = 1, acc_valid = 0, acc_level = 0, tpr_we = 0, ack = 0, eoi = 0;
  logic [7:0] acc_vector = 0, tpr_wdata = 0;
  logic irr_valid, isr_valid, reeval, acc_ok, acc_dup, eoi_valid, eoi_level;
  logic [7:0] irr_vec, isr_vec, ppr, eoi_vec;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl uut (.clk, .rst_n, .sw_en, .acc_valid, .acc_vector, .acc_level,
    .tpr_we, .tpr_wdata, .ack, .eoi, .irr_valid, .irr_vec, .isr_valid, .isr_vec,
    .ppr, .reeval, .acc_ok, .acc_dup, .eoi_valid, .eoi_vec, .eoi_level);

  bit [255:0] pend, serv, trig;
  int tpr, pprev, m_ok, m_dup, m_ev, m_evec, m_elvl;

  function automatic int hi(bit [255:0] a);
    for (int i = 255; i >= 16; i--) if (a[i]) return i;
    return -1;
  endfunction

  function automatic int mppr();
    int hs, iv;
    hs = hi(serv);
    iv = (hs < 0) ? 0 : hs;
    return ((tpr >> 4) >= (iv >> 4)) ? tpr : (iv & 'hF0);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int hp, hs, pnow, v;
    bit ok, dup, ackdo;
    if (!rst_n) begin
      pend = '0; serv = '0; trig = '0; tpr = 0; pprev = 0;
      m_ok = 0; m_dup = 0; m_ev = 0; m_evec = 0; m_elvl = 0;
    end else begin
      hp = hi(pend); hs = hi(serv); pnow = mppr(); v = acc_vector;
      ok = 0; dup = 0;
      m_ev = 0; m_evec = 0; m_elvl = 0;
      if (eoi && hs >= 0) begin m_ev = 1; m_evec = hs; m_elvl = trig[hs]; end
      ackdo = ack && hp >= 0 && ((hp >> 4) > (pnow >> 4));
      if (sw_en && acc_valid && v >= 16) begin
        if (pend[v]) dup = 1; else ok = 1;
      end
      if (m_ev) serv[hs] = 0;
      if (ackdo) begin pend[hp] = 0; serv[hp] = 1; end
      if (ok) pend[v] = 1;
      if (ok || dup) trig[v] = acc_level;
      if (tpr_we) tpr = tpr_wdata;
      pprev = pnow;
      m_ok = ok; m_dup = dup;
    end
  end

  always @(negedge clk) if (rst_n) begin
    int hp, hs;
    hp = hi(pend); hs = hi(serv);
    chk("R4 irr_valid", irr_valid, hp >= 0);
    if (hp >= 0) chk("R4 irr_vec", irr_vec, hp);
    chk("R11 isr_valid", isr_valid, hs >= 0);
    if (hs >= 0) chk("R11 isr_vec", isr_vec, hs);
    chk("R6 ppr", ppr, mppr());
    chk("R9 reeval", reeval, mppr() < pprev);
    chk("R2 acc_ok", acc_ok, m_ok);
    chk("R3 acc_dup", acc_dup, m_dup);
    chk("R8 eoi_valid", eoi_valid, m_ev);
    if (m_ev) begin
      chk("R8 eoi_vec", eoi_vec, m_evec);
      chk("R5 eoi_level", eoi_level, m_elvl);
    end
  end

  task automatic step();
    @(posedge clk); #3;
    acc_valid = 0; tpr_we = 0; ack = 0; eoi = 0; sw_en = 1;
  endtask
  task automatic accept(int v, bit lvl);
    acc_valid = 1; acc_vector = 8'(v); acc_level = lvl; step();
  endtask
  task automatic settpr(int v); tpr_we = 1; tpr_wdata = 8'(v); step(); endtask
  task automatic do_ack(); ack = 1; step(); endtask
  task automatic do_eoi(); eoi = 1; step(); endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    @(negedge clk);
    chk("R1 irr_valid", irr_valid, 0); chk("R1 isr_valid", isr_valid, 0);
    chk("R1 ppr", ppr, 0); chk("R1 eoi_valid", eoi_valid, 0);
    chk("R1 pulses", {reeval, acc_ok, acc_dup}, 0);
    step();
    accept('h05, 1); @(negedge clk);
    chk("R2 low vector ignored", irr_valid, 0); chk("R2 low no pulse", acc_ok | acc_dup, 0);
    step();
    accept('h40, 0); accept('h45, 1); accept('hE1, 0); accept('h20, 1);
    @(negedge clk); chk("R2 accepted", acc_ok, 1);
    step();
    accept('h45, 0); @(negedge clk); chk("R3 duplicate", acc_dup, 1);
    step();
    sw_en = 0; accept('hF0, 1); @(negedge clk);
    chk("R10 disabled accept", irr_vec, 'hE1); chk("R10 no pulse", acc_ok | acc_dup, 0);
    step();
    settpr('h50); @(negedge clk); chk("R6 tpr only", ppr, 'h50);
    step();
    do_ack(); @(negedge clk);
    chk("R7 taken", isr_vec, 'hE1); chk("R6 isr class", ppr, 'hE0); chk("R4 next", irr_vec, 'h45);
    step();
    do_ack(); @(negedge clk); chk("R7 blocked keeps pending", irr_vec, 'h45);
    step();
    do_eoi(); @(negedge clk);
    chk("R8 eoi vec", eoi_vec, 'hE1); chk("R5 edge", eoi_level, 0); chk("R9 drop", reeval, 1);
    step();
    do_ack(); @(negedge clk); chk("R7 class not above", isr_valid, 0);
    step();
    settpr('h10); do_ack(); @(negedge clk);
    chk("R7 taken 45", isr_vec, 'h45); chk("R6 ppr 40", ppr, 'h40);
    step();
    do_eoi(); @(negedge clk); chk("R5 dup rewrote mode", eoi_level, 0);
    step();
    accept('h45, 1); do_ack(); do_eoi(); @(negedge clk);
    chk("R5 level", eoi_level, 1); chk("R8 vec 45", eoi_vec, 'h45);
    step();
    do_eoi(); @(negedge clk); chk("R8 empty eoi", eoi_valid, 0);
    step();
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 99);
      sw_en = ($urandom_range(0, 9) != 0);
      acc_valid = (r < 60); acc_vector = 8'($urandom_range(0, 255)); acc_level = r[0];
      ack = ($urandom_range(0, 3) == 0);
      eoi = ($urandom_range(0, 4) == 0);
      tpr_we = ($urandom_range(0, 15) == 0); tpr_wdata = 8'($urandom_range(0, 255));
      step();
    end
    repeat (2) step();
    finish_run();
  end
endmodule